// File: doc/BRIEF.md
# Armable Debug Event Counter

This block is a debug-support counter. It watches one event source, picked from sixteen select codes, and counts down a programmed number of occurrences. When the count is used up, it raises a one-cycle done pulse. It can run from the moment it is programmed. It can also be armed so that it waits for one of ten trigger sources and then starts counting by itself.

Software programs two registers through a single-cycle write port. The control register holds an enable field and a source-select field. The value register holds the down-counter. Both registers are visible on output ports, so the state can be read back. A trigger rewrites the enable field to the run code on the clock edge after it fires. A trigger also decides whether the enabling event counts: it is counted when the trigger and the counted source are the same detector, and dropped otherwise. The detectors that drive the trigger and event inputs sit outside this block.

Top module: `dbg_event_counter`

## Requirements
- R1: After a synchronous active-low reset, `ctrl_q`, `value_q` and `count_done` are all zero.
- R2: A write with `reg_sel`=0 loads the control register. Bits 7:4 are the enable field and bits 3:0 are the select field. The register reads back on `ctrl_q[7:0]` after the next clock edge.
- R3: Enable codes 1 to 9 arm the counter on `trig_i[code-1]`. When that trigger is high, the enable field becomes 4'hF on the next edge. Enable 4'hF means running.
- R4: When the arming trigger is the same detector as the counted source, the triggering event is counted. Trigger `trig_i[k]` for k 0 to 8 is the same detector as select code k.
- R5: When the arming trigger differs from the counted source, nothing is counted in the trigger cycle.
- R6: While running, every cycle in which the selected source is high decrements `value_q` by one.
- R7: The decrement that reaches zero gives a one-cycle `count_done` pulse in the cycle where `value_q` first reads zero. The value then holds at zero until it is reloaded. A loaded zero never produces a pulse.
- R8: Select codes map as follows:
  - Codes 0 to 11 select `evt_i[code]`.
  - Code 12 counts every clock.
  - Codes 13 and 14 select `evt_i[12]` and `evt_i[13]`.
- R9: Enable code 10 arms on `trig_i[9]`, and only while `ext_in_mode` is 1.
- R10: Enable code 0 and the reserved codes 11 to 14 neither count nor fire. Select code 15 counts nothing.
- R11: A write with `reg_sel`=1 loads bits 30:0 of the value register and clears bit 31, whatever value is written.
- R12: A register write in the same cycle as a trigger rewrite or a decrement wins over the hardware update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 1 | Write target: 0 control, 1 value |
| reg_wdata | input | 32 | Write data |
| trig_i | input | 10 | Arming trigger sources, index = enable code - 1 |
| ext_in_mode | input | 1 | External pin is configured as an input (qualifies trig_i[9]) |
| evt_i | input | 14 | Countable event sources |
| ctrl_q | output | 8 | Control register: enable [7:4], select [3:0] |
| value_q | output | 32 | Down-counter value, bit 31 always zero |
| count_done | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
The bench targets the counting of the enabling event. A design that mixed up the same-source and different-source cases would finish one event early or one event late. It checks that the enable rewrite lands exactly one edge after the trigger: a design that updated the field at once, or too late, would show the wrong `ctrl_q` in the cycle where the bench samples it. Further cases are the stop at zero, the never-firing loaded zero, the pin qualifier on the external trigger, and reserved codes. A design that got these wrong would wrap past zero, pulse twice, or count while it should be idle. Same-cycle write collisions show whether hardware updates wrongly overwrite software writes.

// File: rtl/dbgcnt_pkg.sv
// Package: shared field widths, code points and the control register layout
// for the debug event counter. Assumes 4-bit enable and select fields.
package dbgcnt_pkg;

    localparam int FIELD_W = 4;

    // Enable field code points
    localparam logic [FIELD_W-1:0] EN_OFF      = 4'h0;
    localparam logic [FIELD_W-1:0] EN_RUN      = 4'hF;
    localparam logic [FIELD_W-1:0] EN_LAST_ARM = 4'hA;

    // Select field code points
    localparam int                 SEL_CODES   = 1 << FIELD_W;
    localparam int                 SEL_CLOCK   = 12;
    localparam logic [FIELD_W-1:0] SEL_RSVD    = 4'hF;

    // Control register image: enable in the upper nibble, select in the lower
    typedef struct packed {
        logic [FIELD_W-1:0] en;
        logic [FIELD_W-1:0] sel;
    } ctrl_t;

endpackage

// File: rtl/dbgcnt_src_mux.sv
// Module: selects the event source to count from the 4-bit select code.
// Codes below SEL_CLOCK map straight onto evt_i. SEL_CLOCK counts every cycle.
// Codes above it map onto evt_i shifted down by one. Anything past the
// inputs (the reserved top code) never hits. Purely combinational.
module dbgcnt_src_mux
    import dbgcnt_pkg::*;
#(
    parameter int NUM_EVT = 14
) (
    input  logic [FIELD_W-1:0]  sel,
    input  logic [NUM_EVT-1:0]  evt_i,
    output logic                hit
);

    logic [SEL_CODES-1:0] code_hit;

    // One hit term per select code, chosen at elaboration
    for (genvar c = 0; c < SEL_CODES; c++) begin : g_code
        if (c == SEL_CLOCK) begin : g_clk
            assign code_hit[c] = 1'b1;
        end else if (c < SEL_CLOCK && c < NUM_EVT) begin : g_low
            assign code_hit[c] = evt_i[c];
        end else if (c > SEL_CLOCK && (c - 1) < NUM_EVT) begin : g_high
            assign code_hit[c] = evt_i[c-1];
        end else begin : g_none
            assign code_hit[c] = 1'b0;
        end
    end

    // Pick the term for the current select code
    always_comb hit = code_hit[sel];

endmodule

// File: rtl/dbgcnt_arm.sv
// Module: holds the control register and decides when an armed counter starts.
// Enable codes 1..NUM_TRIG arm on trig_i[code-1]. The last trigger is the
// external pin and is qualified by ext_in_mode. On a firing trigger the enable
// field becomes the run code on the next edge. A software write in the same
// cycle wins. first_counts flags a firing trigger that is also the selected
// source (trigger k pairs with select code k for all but the pin trigger).
module dbgcnt_arm
    import dbgcnt_pkg::*;
#(
    parameter int NUM_TRIG = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_wr,
    input  ctrl_t               ctrl_wdata,
    input  logic [NUM_TRIG-1:0] trig_i,
    input  logic                ext_in_mode,
    output ctrl_t               ctrl,
    output logic                running,
    output logic                arm_fire,
    output logic                first_counts
);

    localparam logic [FIELD_W-1:0] LAST_SAME = FIELD_W'(NUM_TRIG - 1);

    logic [NUM_TRIG-1:0] code_fire;
    logic                same_src;

    // Per-trigger match of the armed code against its trigger input
    for (genvar k = 0; k < NUM_TRIG; k++) begin : g_trig
        if (k == NUM_TRIG - 1) begin : g_pin
            assign code_fire[k] = (ctrl.en == FIELD_W'(k + 1)) & trig_i[k] & ext_in_mode;
        end else begin : g_det
            assign code_fire[k] = (ctrl.en == FIELD_W'(k + 1)) & trig_i[k];
        end
    end

    // Decode run state, trigger fire and the same-source condition
    always_comb begin
        running      = (ctrl.en == EN_RUN);
        arm_fire     = |code_fire;
        same_src     = (ctrl.en != EN_OFF) && (ctrl.en <= LAST_SAME) &&
                       (ctrl.sel == ctrl.en - FIELD_W'(1));
        first_counts = arm_fire && same_src;
    end

    // Control register: software write first, then the hardware rewrite
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl <= ctrl_wdata;
        end else if (arm_fire) begin
            ctrl.en <= EN_RUN;
        end
    end

    a_r3_fire_sets_run: assert property (@(posedge clk) disable iff (!rst_n)
        arm_fire && !ctrl_wr |=> ctrl.en == EN_RUN);

    a_r10_reserved_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en > EN_LAST_ARM || ctrl.en == EN_OFF) |-> !arm_fire);

    a_r12_ctrl_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> ctrl == $past(ctrl_wdata));

endmodule

// File: rtl/dbgcnt_down.sv
// Module: the value register, a down-counter with a forced-zero top bit.
// A load takes the lower VAL_W-1 bits and beats any step. A step decrements
// only while the value is non-zero. The step that reaches zero raises done for
// exactly one cycle, aligned with the value reading zero.
module dbgcnt_down #(
    parameter int VAL_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [VAL_W-1:0] load_data,
    input  logic             step,
    output logic [VAL_W-1:0] value,
    output logic             done
);

    localparam int CNT_W = VAL_W - 1;

    // Load, decrement-with-floor and the registered done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                value <= {1'b0, load_data[CNT_W-1:0]};
            end else if (step && value != '0) begin
                value <= value - VAL_W'(1);
                done  <= (value == VAL_W'(1));
            end
        end
    end

    a_r11_msb_clear: assert property (@(posedge clk) disable iff (!rst_n)
        value[VAL_W-1] == 1'b0);

    a_r6_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load && value != '0 |=> value == $past(value) - VAL_W'(1));

    a_r7_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> value == '0);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_hold_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        value == '0 && !load |=> value == '0 && !done);

endmodule

// File: rtl/dbg_event_counter.sv
// Module: top of the armable debug event counter. Splits the write port between
// the control and value registers and routes the selected source into the
// down-counter. A step is either a selected event while running, or the
// arming event itself when it is the counted source. Assumes single-cycle
// write strobes and inputs synchronous to clk.
module dbg_event_counter
    import dbgcnt_pkg::*;
#(
    parameter int VAL_W    = 32,
    parameter int NUM_TRIG = 10,
    parameter int NUM_EVT  = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_sel,
    input  logic [VAL_W-1:0]     reg_wdata,
    input  logic [NUM_TRIG-1:0]  trig_i,
    input  logic                 ext_in_mode,
    input  logic [NUM_EVT-1:0]   evt_i,
    output logic [2*FIELD_W-1:0] ctrl_q,
    output logic [VAL_W-1:0]     value_q,
    output logic                 count_done
);

    logic  ctrl_wr;
    logic  val_wr;
    ctrl_t ctrl;
    logic  running;
    logic  arm_fire;
    logic  first_counts;
    logic  src_hit;
    logic  count_step;

    // Write decode and step selection
    always_comb begin
        ctrl_wr    = reg_wr && !reg_sel;
        val_wr     = reg_wr && reg_sel;
        count_step = (running && src_hit) || first_counts;
        ctrl_q     = ctrl;
    end

    dbgcnt_arm #(.NUM_TRIG(NUM_TRIG)) u_arm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (ctrl_wr),
        .ctrl_wdata   (ctrl_t'(reg_wdata[2*FIELD_W-1:0])),
        .trig_i       (trig_i),
        .ext_in_mode  (ext_in_mode),
        .ctrl         (ctrl),
        .running      (running),
        .arm_fire     (arm_fire),
        .first_counts (first_counts)
    );

    dbgcnt_src_mux #(.NUM_EVT(NUM_EVT)) u_mux (
        .sel   (ctrl.sel),
        .evt_i (evt_i),
        .hit   (src_hit)
    );

    dbgcnt_down #(.VAL_W(VAL_W)) u_down (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (val_wr),
        .load_data (reg_wdata),
        .step      (count_step),
        .value     (value_q),
        .done      (count_done)
    );

    a_r5_foreign_trigger_uncounted: assert property (@(posedge clk) disable iff (!rst_n)
        arm_fire && !first_counts && !val_wr |=> $stable(value_q));

    a_r10_reserved_select_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.sel == SEL_RSVD && !val_wr |=> $stable(value_q));

    a_r12_value_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        val_wr |=> value_q == {1'b0, $past(reg_wdata[VAL_W-2:0])});

endmodule

// File: tb/dbg_event_counter_bench.sv
`timescale 1ns/1ps
module dbg_event_counter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [9:0]  trig_i = '0;
    logic        ext_in_mode = 1'b0;
    logic [13:0] evt_i = '0;
    logic [7:0]  ctrl_q;
    logic [31:0] value_q;
    logic        count_done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dbg_event_counter u_dbg_event_counter (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .trig_i(trig_i), .ext_in_mode(ext_in_mode),
        .evt_i(evt_i), .ctrl_q(ctrl_q), .value_q(value_q), .count_done(count_done)
    );

    // ---------------- behavioural reference model ----------------
    int     m_en = 0, m_sel = 0;
    longint m_val = 0;
    bit     m_done = 0;
    bit     f_fire, f_same, f_hit, f_step;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_sel = 0; m_val = 0; m_done = 0;
        end else begin
            f_fire = 0;
            if (m_en >= 1 && m_en <= 10)
                f_fire = trig_i[m_en-1] && (m_en != 10 || ext_in_mode);
            f_same = f_fire && m_en <= 9 && m_sel == m_en - 1;
            if (m_sel < 12)       f_hit = evt_i[m_sel];
            else if (m_sel == 12) f_hit = 1;
            else if (m_sel < 15)  f_hit = evt_i[m_sel-1];
            else                  f_hit = 0;
            f_step = (m_en == 15 && f_hit) || f_same;
            m_done = 0;
            if (reg_wr && reg_sel) begin
                m_val = reg_wdata & 32'h7FFF_FFFF;
            end else if (f_step && m_val != 0) begin
                m_val  = m_val - 1;
                m_done = (m_val == 0);
            end
            if (reg_wr && !reg_sel) begin
                m_en = reg_wdata[7:4]; m_sel = reg_wdata[3:0];
            end else if (f_fire) begin
                m_en = 15;
            end
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 ctrl model", ctrl_q, (m_en << 4) | m_sel);
            chk("R6 value model", value_q, m_val);
            chk("R7 done model", count_done, m_done);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic sel, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [9:0] t, input logic [13:0] e);
        trig_i = t; evt_i = e;
        @(negedge clk);
        trig_i = '0; evt_i = '0;
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset ctrl", ctrl_q, 0);
        chk("R1 reset value", value_q, 0);
        chk("R1 reset done", count_done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R6 / R7: direct run on evt_i[0]
        wr(0, 32'h0000_00F0);
        chk("R2 ctrl readback", ctrl_q, 8'hF0);
        wr(1, 32'd3);
        pulse('0, 14'h1);
        chk("R6 first decrement", value_q, 2);
        pulse('0, 14'h1);
        pulse('0, 14'h1);
        chk("R7 reach zero", value_q, 0);
        chk("R7 done pulse", count_done, 1);
        @(negedge clk);
        chk("R7 pulse one cycle", count_done, 0);
        pulse('0, 14'h1);
        chk("R7 hold at zero", value_q, 0);
        chk("R7 no second pulse", count_done, 0);

        // R3 / R4: armed on trig_i[1], counting select 1 (same source)
        wr(0, 32'h0000_0021);
        wr(1, 32'd2);
        pulse(10'h002, 14'h0002);
        chk("R3 enable rewritten", ctrl_q, 8'hF1);
        chk("R4 enabling event counted", value_q, 1);
        pulse('0, 14'h0002);
        chk("R4 done after second", count_done, 1);

        // R5: armed on trig_i[2], counting select 5
        wr(0, 32'h0000_0035);
        wr(1, 32'd2);
        pulse(10'h004, 14'h0020);
        chk("R3 enable rewritten differ", ctrl_q, 8'hF5);
        chk("R5 enabling event not counted", value_q, 2);
        pulse('0, 14'h0020);
        chk("R5 counting after enable", value_q, 1);

        // R9: external pin trigger needs ext_in_mode
        wr(0, 32'h0000_00A0);
        ext_in_mode = 1'b0;
        pulse(10'h200, '0);
        chk("R9 pin ignored as output", ctrl_q, 8'hA0);
        ext_in_mode = 1'b1;
        pulse(10'h200, '0);
        chk("R9 pin fires as input", ctrl_q, 8'hF0);

        // R8: every-clock code and the shifted high codes
        wr(0, 32'h0000_00FC);
        wr(1, 32'd5);
        repeat (4) @(negedge clk);
        chk("R8 clock count", value_q, 1);
        @(negedge clk);
        chk("R8 clock count done", count_done, 1);
        wr(0, 32'h0000_00FD);
        wr(1, 32'd2);
        pulse('0, 14'h1000);
        chk("R8 code 13 uses evt 12", value_q, 1);
        pulse('0, 14'h0FFF);
        chk("R8 code 13 ignores others", value_q, 1);

        // R10: reserved enable, disabled, reserved select
        wr(1, 32'd3);
        wr(0, 32'h0000_00C0);
        pulse(10'h3FF, 14'h3FFF);
        pulse(10'h3FF, 14'h3FFF);
        chk("R10 reserved enable ctrl", ctrl_q, 8'hC0);
        chk("R10 reserved enable value", value_q, 3);
        wr(0, 32'h0000_0000);
        pulse(10'h3FF, 14'h3FFF);
        chk("R10 disabled value", value_q, 3);
        wr(0, 32'h0000_00FF);
        pulse('0, 14'h3FFF);
        pulse('0, 14'h3FFF);
        chk("R10 reserved select value", value_q, 3);

        // R11: top bit forced clear
        wr(1, 32'hFFFF_FFFF);
        chk("R11 msb cleared", value_q, 32'h7FFF_FFFF);

        // R12: write against trigger rewrite, write against decrement
        wr(0, 32'h0000_0040);
        trig_i = 10'h008;
        wr(0, 32'h0000_0002);
        trig_i = '0;
        chk("R12 ctrl write beats rewrite", ctrl_q, 8'h02);
        wr(0, 32'h0000_00F0);
        wr(1, 32'd5);
        evt_i = 14'h1;
        wr(1, 32'd9);
        evt_i = '0;
        chk("R12 value write beats decrement", value_q, 9);
        wr(1, 32'd1);
        evt_i = 14'h1;
        wr(1, 32'd4);
        evt_i = '0;
        chk("R12 no pulse on overwritten final step", count_done, 0);

        // R7: loaded zero never pulses
        wr(0, 32'h0000_00FC);
        wr(1, 32'd0);
        repeat (3) @(negedge clk);
        chk("R7 loaded zero no pulse", count_done, 0);
        chk("R7 loaded zero holds", value_q, 0);

        // Random traffic, compared against the model every cycle
        for (int i = 0; i < 6000; i++) begin
            reg_wr      = ($urandom % 10) == 0;
            reg_sel     = $urandom % 2;
            reg_wdata   = reg_sel ? ($urandom & 32'h8000_001F) : {24'h0, 8'($urandom)};
            trig_i      = 10'($urandom & $urandom & $urandom);
            evt_i       = 14'($urandom & $urandom);
            ext_in_mode = $urandom % 2;
            @(negedge clk);
        end
        reg_wr = 1'b0; trig_i = '0; evt_i = '0;
        @(negedge clk);
        summary();
    end

endmodule